// File: doc/BRIEF.md
# Interrupt Request Capture Controller

This block collects eight interrupt request lines, picks the most urgent one under a fixed priority, and raises a single interrupt line toward a processor. The processor answers with a two-pulse acknowledge. The controller freezes the winning input on the first pulse and presents that input's 3-bit number on the vector output during the second pulse. The processor later returns an end-of-interrupt command, which releases the in-service bit of the serviced input.

Each input has three state bits. The request bit is what the resolver sees. The in-service bit marks an interrupt that has been acknowledged and not yet retired. The edge-sense bit is set after acknowledge and blocks the request bit in edge mode, so that an input held high is served only once. The edge-sense bit is released only when the input has dropped and its in-service bit is clear. If a request is withdrawn before the first acknowledge pulse ends, the acknowledge still completes, but it returns the lowest-priority code (7) and marks nothing in service. In level mode the edge-sense gating is bypassed, and the request bit simply follows the input.

The request lines and the acknowledge strobe are asynchronous and pass through two synchronizer stages. The end-of-interrupt command uses a valid/ready handshake. Ready is low from the first acknowledge pulse until the second pulse ends, so a command offered in that window waits, with its fields held, until ready returns.

Top module: `irq_capture_ctrl`

## Requirements
- R1: After reset, `int_out` is 0, `vec_valid` is 0 and `eoi_ready` is 1.
- R2: Priority is fixed, with input 0 highest and input 7 lowest. The vector returned is the binary index of the lowest-numbered pending unmasked input.
- R3: An input whose `mask_in` bit is 1 neither raises `int_out` nor wins the acknowledge.
- R4: `int_out` is 1 only when a pending request has a strictly lower index than every set in-service bit. A higher-priority request raises it while a lower one is in service.
- R5: `vec_valid` is 0 during the first acknowledge pulse. It is 1 during the second pulse, and `vec_out` then holds the 3-bit code.
- R6: If the winning request drops before the first acknowledge pulse falls, the second pulse returns code 7 and no in-service bit is set.
- R7: In edge mode, an input that stays high after its end-of-interrupt does not raise `int_out` again.
- R8: In level mode (`level_mode`=1), an input that is still high after its end-of-interrupt raises `int_out` again.
- R9: A non-specific end-of-interrupt (`eoi_specific`=0) clears the lowest-numbered set in-service bit.
- R10: A specific end-of-interrupt (`eoi_specific`=1) clears the in-service bit given by `eoi_id`, whatever its priority.
- R11: A request that rises and falls with no acknowledge leaves nothing pending: `int_out` returns to 0 and stays 0.
- R12: `eoi_ready` is 0 from the first acknowledge pulse until the second pulse ends.
- R13: In edge mode, once the input drops with its in-service bit clear, a new rising request raises `int_out` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 8 | Asynchronous request lines, bit 0 highest priority |
| mask_in | input | 8 | 1 blocks the matching request |
| level_mode | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_in | input | 1 | Asynchronous acknowledge strobe, two pulses per cycle |
| eoi_valid | input | 1 | End-of-interrupt command offered |
| eoi_specific | input | 1 | 1 = clear `eoi_id`, 0 = clear the highest-priority in-service bit |
| eoi_id | input | 3 | Input number for a specific command |
| eoi_ready | output | 1 | Command accepted when high together with `eoi_valid` |
| int_out | output | 1 | Interrupt line to the processor |
| vec_valid | output | 1 | High during the second acknowledge pulse |
| vec_out | output | 3 | Vector code of the acknowledged input, or 7 as the default |

## Verification
The hardest situation to reach is a request withdrawn between the start of the first acknowledge pulse and its falling edge. The stimulus raises the acknowledge and waits for the winner to freeze. It then drops the request line and waits past the synchronizer and request register before the pulse falls. It then checks that the default code comes out and, by raising a lower-priority input, that nothing was marked in service. Nested service with mixed specific and non-specific commands is reached by holding several edge-mode inputs high across staggered acknowledges.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int unsigned NUM_IN = 8;
  localparam int unsigned ID_W   = $clog2(NUM_IN);

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FIRST = 2'd1,
    SQ_GAP   = 2'd2,
    SQ_SECOND = 2'd3
  } ack_phase_e;
endpackage

// File: rtl/irq_cap_sync.sv
module irq_cap_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_async;
      for (int s = 1; s < int'(STAGES); s++) chain[s] <= chain[s-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_cap_lane.sv
module irq_cap_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_s,
  input  logic level_mode,
  input  logic commit,
  input  logic eoi_clr,
  output logic irr,
  output logic isr
);
  logic esl;
  logic commit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr      <= 1'b0;
      esl      <= 1'b0;
      commit_q <= 1'b0;
      irr      <= 1'b0;
    end else begin
      commit_q <= commit;
      isr      <= (isr & ~eoi_clr) | commit;
      if (commit_q)
        esl <= 1'b1;
      else if (!irq_s && !isr)
        esl <= 1'b0;
      irr <= irq_s & (level_mode | ~esl);
    end
  end

  p_isr_set_by_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr) |-> $past(commit));
  p_isr_clear_by_eoi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isr) |-> $past(eoi_clr));
  p_esl_follows_isr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esl) |-> isr);
endmodule

// File: rtl/irq_cap_resolver.sv
module irq_cap_resolver #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  input  logic [N-1:0]  mask,
  output logic          int_req,
  output logic          win_found,
  output logic [IW-1:0] win_id,
  output logic          isr_any,
  output logic [IW-1:0] isr_top
);
  logic [N-1:0] pend;

  always_comb begin
    pend      = irr & ~mask;
    win_found = 1'b0;
    win_id    = '0;
    isr_any   = 1'b0;
    isr_top   = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_found = 1'b1;
        win_id    = IW'(i);
      end
      if (isr[i]) begin
        isr_any = 1'b1;
        isr_top = IW'(i);
      end
    end
    int_req = win_found && (!isr_any || (win_id < isr_top));
  end
endmodule

// File: rtl/irq_cap_ack_seq.sv
module irq_cap_ack_seq
  import irq_cap_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ack_s,
  input  logic          int_req,
  input  logic [IW-1:0] win_id,
  input  logic [N-1:0]  irr,
  output logic [N-1:0]  commit,
  output logic          idle,
  output logic          vec_valid,
  output logic [IW-1:0] vec_out
);
  localparam logic [IW-1:0] DEF_ID = IW'(N - 1);

  ack_phase_e    phase;
  logic          ack_q;
  logic          frozen_ok;
  logic [IW-1:0] frozen_id;
  logic          rise, fall;

  assign rise = ack_s & ~ack_q;
  assign fall = ~ack_s & ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= SQ_IDLE;
      ack_q     <= 1'b0;
      frozen_ok <= 1'b0;
      frozen_id <= '0;
      commit    <= '0;
      vec_out   <= '0;
    end else begin
      ack_q  <= ack_s;
      commit <= '0;
      unique case (phase)
        SQ_IDLE: if (rise) begin
          phase     <= SQ_FIRST;
          frozen_ok <= int_req;
          frozen_id <= win_id;
        end
        SQ_FIRST: if (fall) begin
          phase <= SQ_GAP;
          if (frozen_ok && irr[frozen_id]) begin
            commit[frozen_id] <= 1'b1;
            vec_out           <= frozen_id;
          end else begin
            vec_out <= DEF_ID;
          end
        end
        SQ_GAP:    if (rise) phase <= SQ_SECOND;
        SQ_SECOND: if (fall) phase <= SQ_IDLE;
        default:   phase <= SQ_IDLE;
      endcase
    end
  end

  assign idle      = (phase == SQ_IDLE);
  assign vec_valid = (phase == SQ_SECOND);

  p_vec_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && $past(vec_valid) |-> $stable(vec_out));
  p_commit_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(commit));
  p_commit_in_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|commit) |-> (phase == SQ_GAP));
endmodule

// File: rtl/irq_capture_ctrl.sv
module irq_capture_ctrl
  import irq_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] mask_in,
  input  logic            level_mode,
  input  logic            ack_in,
  input  logic            eoi_valid,
  input  logic            eoi_specific,
  input  logic [ID_W-1:0] eoi_id,
  output logic            eoi_ready,
  output logic            int_out,
  output logic            vec_valid,
  output logic [ID_W-1:0] vec_out
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [NUM_IN-1:0] irq_s, irr, isr, commit, eoi_clr;
  logic              ack_s, seq_idle, win_found, isr_any;
  logic [ID_W-1:0]   win_id, isr_top;

  irq_cap_sync #(.WIDTH(NUM_IN + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({ack_in, irq_in}),
    .d_sync({ack_s, irq_s})
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_lane
    irq_cap_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .irq_s(irq_s[g]), .level_mode(level_mode),
      .commit(commit[g]), .eoi_clr(eoi_clr[g]),
      .irr(irr[g]), .isr(isr[g])
    );
  end

  irq_cap_resolver #(.N(NUM_IN), .IW(ID_W)) u_res (
    .irr(irr), .isr(isr), .mask(mask_in),
    .int_req(int_out), .win_found(win_found), .win_id(win_id),
    .isr_any(isr_any), .isr_top(isr_top)
  );

  irq_cap_ack_seq #(.N(NUM_IN), .IW(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ack_s(ack_s),
    .int_req(int_out), .win_id(win_id), .irr(irr),
    .commit(commit), .idle(seq_idle),
    .vec_valid(vec_valid), .vec_out(vec_out)
  );

  assign eoi_ready = seq_idle;

  always_comb begin
    eoi_clr = '0;
    if (eoi_valid && eoi_ready) begin
      if (eoi_specific)      eoi_clr[eoi_id]  = 1'b1;
      else if (isr_any)      eoi_clr[isr_top] = 1'b1;
    end
  end

  p_ready_low_in_seq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !eoi_ready);
  p_int_needs_request_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask_in) != '0));
  p_eoi_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_clr));
endmodule

// File: tb/irq_capture_ctrl_tb_top.sv
module irq_capture_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  SETTLE = 6;
  // each entry: {irq[7:0], mask[7:0], exp_int, exp_vec[2:0]}
  localparam logic [19:0] VEC_TBL [0:5] = '{
    20'h01008, 20'h8000F, 20'h2400A, 20'hF010D, 20'h08080, 20'hC000E
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, mask_in = '0;
  logic level_mode = 1'b0, ack_in = 1'b0;
  logic eoi_valid = 1'b0, eoi_specific = 1'b0;
  logic [2:0] eoi_id = '0;
  logic eoi_ready, int_out, vec_valid;
  logic [2:0] vec_out;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_capture_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .mask_in(mask_in),
    .level_mode(level_mode), .ack_in(ack_in), .eoi_valid(eoi_valid),
    .eoi_specific(eoi_specific), .eoi_id(eoi_id), .eoi_ready(eoi_ready),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack_first_rise();
    ack_in = 1'b1; wait_cyc(SETTLE);
  endtask

  task automatic ack_rest(input int exp_vec, input string req);
    check(vec_valid == 1'b0, "R5", vec_valid, 0);
    ack_in = 1'b0; wait_cyc(SETTLE);
    check(eoi_ready == 1'b0, "R12", eoi_ready, 0);
    ack_in = 1'b1; wait_cyc(SETTLE);
    check(vec_valid == 1'b1, "R5", vec_valid, 1);
    check(vec_out == 3'(exp_vec), req, vec_out, exp_vec);
    ack_in = 1'b0; wait_cyc(SETTLE);
  endtask

  task automatic do_ack(input int exp_vec, input string req);
    ack_first_rise();
    ack_rest(exp_vec, req);
  endtask

  task automatic send_eoi(input logic spec, input int id);
    eoi_valid = 1'b1; eoi_specific = spec; eoi_id = 3'(id);
    while (!eoi_ready) @(negedge clk);
    @(negedge clk);
    eoi_valid = 1'b0;
    wait_cyc(SETTLE);
  endtask

  initial begin
    wait_cyc(3);
    // R1 reset state
    check(int_out == 1'b0, "R1", int_out, 0);
    check(vec_valid == 1'b0, "R1", vec_valid, 0);
    check(eoi_ready == 1'b1, "R1", eoi_ready, 1);
    rst_n = 1'b1; wait_cyc(2);

    // R2/R3 table walk
    for (int k = 0; k < 6; k++) begin
      irq_in = VEC_TBL[k][19:12]; mask_in = VEC_TBL[k][11:4];
      wait_cyc(SETTLE);
      check(int_out == VEC_TBL[k][3], "R2/R3 int", int_out, VEC_TBL[k][3]);
      if (VEC_TBL[k][3]) do_ack(int'(VEC_TBL[k][2:0]), "R2 vector");
      irq_in = '0; wait_cyc(SETTLE);
      if (VEC_TBL[k][3]) send_eoi(1'b1, int'(VEC_TBL[k][2:0]));
      mask_in = '0; wait_cyc(SETTLE);
      check(int_out == 1'b0, "R3 idle", int_out, 0);
    end

    // R4 / R9 / R10 nesting
    irq_in = 8'h08; wait_cyc(SETTLE); do_ack(3, "R4");
    irq_in = 8'h0A; wait_cyc(SETTLE);
    check(int_out == 1'b1, "R4 preempt", int_out, 1);
    do_ack(1, "R4");
    irq_in = 8'h0E; wait_cyc(SETTLE);
    check(int_out == 1'b0, "R4 blocked", int_out, 0);
    send_eoi(1'b0, 0);
    check(int_out == 1'b1, "R9", int_out, 1);
    do_ack(2, "R9");
    send_eoi(1'b1, 3);
    send_eoi(1'b0, 0);
    irq_in = 8'h1E; wait_cyc(SETTLE);
    check(int_out == 1'b1, "R10", int_out, 1);
    do_ack(4, "R10");
    irq_in = '0; wait_cyc(SETTLE); send_eoi(1'b1, 4);

    // R7 / R13 edge mode
    irq_in = 8'h20; wait_cyc(SETTLE); do_ack(5, "R7");
    send_eoi(1'b1, 5);
    check(int_out == 1'b0, "R7", int_out, 0);
    irq_in = '0; wait_cyc(SETTLE);
    irq_in = 8'h20; wait_cyc(SETTLE);
    check(int_out == 1'b1, "R13", int_out, 1);
    do_ack(5, "R13");
    irq_in = '0; wait_cyc(SETTLE); send_eoi(1'b1, 5);

    // R8 level mode
    level_mode = 1'b1;
    irq_in = 8'h40; wait_cyc(SETTLE); do_ack(6, "R8");
    send_eoi(1'b1, 6);
    check(int_out == 1'b1, "R8", int_out, 1);
    do_ack(6, "R8");
    irq_in = '0; wait_cyc(SETTLE); send_eoi(1'b1, 6);
    level_mode = 1'b0; wait_cyc(SETTLE);

    // R6 early withdrawal
    irq_in = 8'h04; wait_cyc(SETTLE);
    ack_first_rise();
    irq_in = '0; wait_cyc(SETTLE);
    ack_rest(7, "R6");
    check(int_out == 1'b0, "R6 none", int_out, 0);
    irq_in = 8'h08; wait_cyc(SETTLE);
    check(int_out == 1'b1, "R6 no isr", int_out, 1);
    do_ack(3, "R6");
    irq_in = '0; wait_cyc(SETTLE); send_eoi(1'b1, 3);

    // R11 no acknowledge
    irq_in = 8'h02; wait_cyc(SETTLE);
    check(int_out == 1'b1, "R11 seen", int_out, 1);
    irq_in = '0; wait_cyc(2 * SETTLE);
    check(int_out == 1'b0, "R11 gone", int_out, 0);
    irq_in = 8'h80; wait_cyc(SETTLE);
    do_ack(7, "R11");
    irq_in = '0; wait_cyc(SETTLE); send_eoi(1'b1, 7);
    check(int_out == 1'b0, "R11 quiet", int_out, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule